// File: doc/BRIEF.md
# Ripple Two's-Complement Adder/Subtractor

This block forms the sum or the difference of two small two's-complement operands in purely combinational logic. A single operation bit picks the function. When the bit is low, the operands are added. When the bit is high, the second operand is inverted bit by bit through XOR gates, and the same bit enters the carry chain as its initial carry. The chain therefore computes the first operand plus the complement of the second plus one.

The arithmetic is a chain of identical full-adder cells, with the carry passing from the least significant cell upward. Each cell is built from two XORs, two ANDs and one OR. The block drives three outputs:
- the result word;
- the raw carry leaving the top cell, which means "no borrow" during subtraction;
- a signed overflow flag, formed as the XOR of the carries entering and leaving the most significant cell.

The block has no clock, registers or handshake. A surrounding datapath places it between its own pipeline stages.

Top module: `ripple_addsub`

## Requirements
- R1: With `sub_i` = 0 (add), `sum_o` equals (`opa_i` + `opb_i`) modulo 2^W.
- R2: With `sub_i` = 0, `cout_o` equals bit W of the unsigned sum `opa_i` + `opb_i`.
- R3: With `sub_i` = 1 (subtract), `sum_o` equals (`opa_i` − `opb_i`) modulo 2^W.
- R4: With `sub_i` = 1, `cout_o` is 1 exactly when `opa_i` ≥ `opb_i` as unsigned values (no borrow).
- R5: With `sub_i` = 0, `ovf_o` is 1 exactly when the signed sum of the two operands lies outside −2^(W−1) … 2^(W−1)−1.
- R6: With `sub_i` = 1, `ovf_o` is 1 exactly when the signed difference `opa_i` − `opb_i` lies outside −2^(W−1) … 2^(W−1)−1.
- R7: The longest carry path behaves correctly. All-ones plus one gives `sum_o` = 0, `cout_o` = 1 and `ovf_o` = 0.
- R8: Subtracting zero returns `opa_i` unchanged, with `cout_o` = 1 and `ovf_o` = 0. This shows that the forced initial carry cancels the all-ones complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First operand (minuend in subtract mode) |
| opb_i | input | W | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| sum_o | output | W | Result word |
| cout_o | output | 1 | Carry out of the top cell; in subtract mode 1 means no borrow |
| ovf_o | output | 1 | Signed overflow of the result |

## Verification
The bench builds the block with its default width W = 4. That width keeps the whole input space small: all 512 combinations of both operands and the operation bit are applied. Every carry pattern, every signed overflow boundary and every borrow case is therefore reached, and the longest ripple path and the subtract-zero case are checked explicitly in addition.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/addsub_fa_cell.sv
// One full-adder cell: two XORs, two ANDs, one OR.
module addsub_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic prop;
  logic gen;
  logic pass;

  always_comb begin
    prop = x_i ^ y_i;
    gen  = x_i & y_i;
    pass = prop & ci_i;
    s_o  = prop ^ ci_i;
    co_o = pass | gen;
  end
endmodule

// File: rtl/addsub_operand_cond.sv
// Conditionally complements the second operand, one XOR per bit.
module addsub_operand_cond #(
  parameter int W = 4
) (
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  output logic [W-1:0] b_o
);
  for (genvar k = 0; k < W; k++) begin : g_inv
    assign b_o[k] = b_i[k] ^ inv_i;
  end
endmodule

// File: rtl/addsub_ripple_chain.sv
// Chain of full-adder cells; exposes every carry node.
module addsub_ripple_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c0_i,
  output logic [W-1:0] s_o,
  output logic [W:0]   c_o
);
  assign c_o[0] = c0_i;

  for (genvar k = 0; k < W; k++) begin : g_cell
    addsub_fa_cell u_cell (
      .x_i  (x_i[k]),
      .y_i  (y_i[k]),
      .ci_i (c_o[k]),
      .s_o  (s_o[k]),
      .co_o (c_o[k+1])
    );
  end
endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  addsub_op_e   op;
  logic         inj;
  logic [W-1:0] b_eff;
  logic [W:0]   carry;

  assign op  = addsub_op_e'(sub_i);
  assign inj = (op == OP_SUB);

  addsub_operand_cond #(.W(W)) u_cond (
    .b_i   (opb_i),
    .inv_i (inj),
    .b_o   (b_eff)
  );

  addsub_ripple_chain #(.W(W)) u_chain (
    .x_i  (opa_i),
    .y_i  (b_eff),
    .c0_i (inj),
    .s_o  (sum_o),
    .c_o  (carry)
  );

  assign cout_o = carry[W];
  assign ovf_o  = carry[W] ^ carry[MSB];
endmodule

// File: rtl/ripple_addsub_chk.sv
module ripple_addsub_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         sub_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic         ovf_o
);
  logic [W:0] wide_add;
  logic [W:0] wide_sub;
  logic       same_sign;
  logic       diff_sign;

  always_comb begin
    wide_add  = {1'b0, opa_i} + {1'b0, opb_i};
    wide_sub  = {1'b0, opa_i} - {1'b0, opb_i};
    same_sign = (opa_i[W-1] == opb_i[W-1]);
    diff_sign = (opa_i[W-1] != opb_i[W-1]);
    if (!$isunknown({opa_i, opb_i, sub_i})) begin
      p_add_word_r1: assert (sub_i || sum_o == wide_add[W-1:0]);
      p_add_carry_r2: assert (sub_i || cout_o == wide_add[W]);
      p_sub_word_r3: assert (!sub_i || sum_o == wide_sub[W-1:0]);
      p_no_borrow_r4: assert (!sub_i || cout_o == (opa_i >= opb_i));
      p_add_ovf_r5: assert (sub_i || ovf_o == (same_sign && sum_o[W-1] != opa_i[W-1]));
      p_sub_ovf_r6: assert (!sub_i || ovf_o == (diff_sign && sum_o[W-1] != opa_i[W-1]));
      p_sub_zero_r8: assert (!(sub_i && opb_i == '0) || (sum_o == opa_i && cout_o && !ovf_o));
    end
  end
endmodule

bind ripple_addsub ripple_addsub_chk #(.W(W)) u_chk (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .sub_i  (sub_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .ovf_o  (ovf_o)
);

// File: tb/sim_ripple_addsub.sv
`timescale 1ns/1ps
module sim_ripple_addsub;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         sub = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ripple_addsub #(.W(W)) u0 (
    .opa_i  (opa),
    .opb_i  (opb),
    .sub_i  (sub),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
               tag, opa, opb, sub, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit s);
    @(posedge clk);
    #1;
    opa = a[W-1:0];
    opb = b[W-1:0];
    sub = s;
    #2;
  endtask

  function automatic int sgn(input int v);
    return (v >= HALF) ? v - SPAN : v;
  endfunction

  task automatic compare_model(input int a, input int b, input bit s);
    int full;
    int sres;
    full = s ? a + (SPAN - 1 - b) + 1 : a + b;
    sres = s ? sgn(a) - sgn(b) : sgn(a) + sgn(b);
    if (!s) begin
      check("R1 add word", int'(sum), full % SPAN);
      check("R2 add carry", int'(cout), full / SPAN);
      check("R5 add overflow", int'(ovf), int'(sres < -HALF || sres > HALF - 1));
    end else begin
      check("R3 sub word", int'(sum), full % SPAN);
      check("R4 no borrow", int'(cout), int'(a >= b));
      check("R6 sub overflow", int'(ovf), int'(sres < -HALF || sres > HALF - 1));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Reset state: zero inputs give a zero result with no flags.
    #3;
    check("R1 reset word", int'(sum), 0);
    check("R2 reset carry", int'(cout), 0);
    check("R5 reset overflow", int'(ovf), 0);

    // R7: longest carry path, all ones plus one.
    apply(SPAN - 1, 1, 1'b0);
    check("R7 ripple word", int'(sum), 0);
    check("R7 ripple carry", int'(cout), 1);
    check("R7 ripple overflow", int'(ovf), 0);

    // R8: subtracting zero.
    apply(5, 0, 1'b1);
    check("R8 sub zero word", int'(sum), 5);
    check("R8 sub zero carry", int'(cout), 1);
    check("R8 sub zero overflow", int'(ovf), 0);

    // Signed boundaries: most negative minus one, most positive plus one.
    apply(HALF, 1, 1'b1);
    check("R6 min minus one", int'(ovf), 1);
    apply(HALF - 1, 1, 1'b0);
    check("R5 max plus one", int'(ovf), 1);

    // Exhaustive sweep against the behavioural model.
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          apply(a, b, m[0]);
          compare_model(a, b, m[0]);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule